// File: doc/BRIEF.md
# Vector Unsigned Fixed-Point to Float Converter

This block turns a 128-bit vector of four unsigned 32-bit fixed-point words into four IEEE-754 single-precision values. Each word is taken as an unsigned Q-format number whose fractional bit count comes from a 5-bit scale. The scale is pulled from a fixed field of a 32-bit instruction word that travels with the operand. Every output lane holds the word's integer value divided by two to the power of the scale. The result is always rounded to nearest, with ties going to the even mantissa.

The block sits in a vector execution pipe. Operands enter through a valid/ready handshake and results leave through a second one. In between is a two-register pipeline. When the consumer stalls, the output is held and the input side stops accepting. The block raises no flags, status or exceptions.

Top module: `ufix_vec_to_float`

## Requirements
- R1: The vector holds four independent 32-bit lanes. Lane 0 occupies bits [127:96] and lane 3 occupies bits [31:0]. Each output lane depends only on the same input lane and the scale.
- R2: Each output lane equals the unsigned lane value divided by 2^S. S is instrWord bits [20:16], which are big-endian bit positions 11 through 15. All other instrWord bits have no effect on the result.
- R3: A result that is not exactly representable is rounded to nearest, with ties to even. Inputs above 2^24 therefore round rather than truncate.
- R4: An input lane of zero gives 0x00000000 for every scale.
- R5: The sign bit (bit 31) of every output lane is always 0.
- R6: An operand accepted at a clock edge while the output is not stalled appears at outVec with outValid high two edges later. outValid is low in the cycle between.
- R7: While outValid is high and outReady is low, outValid and outVec keep their values.
- R8: When the output is stalled and the internal stage is occupied, inReady is low and no operand is accepted. Results leave in the order their operands entered, one result per operand.
- R9: During and right after reset, outValid is low and inReady is high.
- R10: Every nonzero result is a normal number with a biased exponent between 96 and 159. No infinity, NaN or subnormal is ever produced.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand offered |
| inReady | output | 1 | Operand can be taken this cycle |
| inVec | input | 128 | Four unsigned fixed-point lanes, lane 0 in the top word |
| instrWord | input | 32 | Instruction word; bits [20:16] carry the scale |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result this cycle |
| outVec | output | 128 | Four single-precision results, lane 0 in the top word |

## Verification
Exact small values such as 1, 3, 7 and 255 at scales 0, 1 and 8 show that the exponent adjustment and the lane order are right. The all-ones and top-bit words at scales 0 and 31 reach both ends of the exponent range, including the carry out of the mantissa when rounding up. The values 2^24+1, 2^24+3 and 2^25+3 separate ties-to-even from round-half-up and from truncation. A scale word with every other instruction bit set shows that only the scale field matters. Zero lanes at several scales, and a stall that holds two operands in flight, cover the zero mapping and the handshake.

// File: rtl/vuf_pkg.sv
package vuf_pkg;
  localparam int WORD_W   = 32;
  localparam int MANT_W   = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;

  typedef struct packed {
    logic loadS1;
    logic loadS2;
  } ctrlStrobe_t;
endpackage

// File: rtl/vuf_lane_cvt.sv
module vuf_lane_cvt
  import vuf_pkg::*;
#(
  parameter int SCALE_W = 5
) (
  input  logic [WORD_W-1:0]  fixIn,
  input  logic [SCALE_W-1:0] scale,
  output logic [WORD_W-1:0]  fltOut
);
  localparam int POS_W   = $clog2(WORD_W);
  localparam int GUARD_I = WORD_W - 2 - MANT_W;
  localparam int XW      = EXP_W + 1;

  logic [POS_W-1:0]  leadPos;
  logic              isZero;
  logic [WORD_W-1:0] normWord;
  logic [MANT_W-1:0] mantTrunc;
  logic              guardBit, stickyBit, roundUp;
  logic [MANT_W:0]   mantSum;
  logic [XW-1:0]     expVal;
  logic              unusedBits;

  // priority encoder: highest set bit wins
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (fixIn[i]) leadPos = POS_W'(i);
    end
  end

  assign isZero    = (fixIn == '0);
  assign normWord  = fixIn << (POS_W'(WORD_W - 1) - leadPos);
  assign mantTrunc = normWord[WORD_W-2 -: MANT_W];
  assign guardBit  = normWord[GUARD_I];
  assign stickyBit = |normWord[GUARD_I-1:0];
  assign roundUp   = guardBit & (stickyBit | normWord[GUARD_I+1]);
  assign mantSum   = {1'b0, mantTrunc} + (MANT_W+1)'(roundUp);
  assign expVal    = XW'(EXP_BIAS) + XW'(leadPos) - XW'(scale) + XW'(mantSum[MANT_W]);
  assign fltOut    = isZero ? '0 : {1'b0, expVal[EXP_W-1:0], mantSum[MANT_W-1:0]};
  assign unusedBits = normWord[WORD_W-1] ^ expVal[XW-1];
endmodule

// File: rtl/vuf_ctrl.sv
module vuf_ctrl
  import vuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic s1Valid, s2Valid, advance;

  assign advance  = !s2Valid || outReady;
  assign inReady  = advance;
  assign outValid = s2Valid;
  assign strobe.loadS1 = advance & inValid;
  assign strobe.loadS2 = advance & s1Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (advance) begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> s1Valid); // R6
  AST_FILL_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1Valid && inReady) |=> outValid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid); // R7
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady); // R8
endmodule

// File: rtl/vuf_datapath.sv
module vuf_datapath
  import vuf_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SCALE_W   = 5,
  parameter int SCALE_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlStrobe_t                 strobe,
  input  logic [NUM_LANES*WORD_W-1:0] inVec,
  input  logic [WORD_W-1:0]           instrWord,
  output logic [NUM_LANES*WORD_W-1:0] outVec
);
  localparam int VEC_W = NUM_LANES * WORD_W;

  logic [VEC_W-1:0]   vecS1;
  logic [SCALE_W-1:0] scaleS1;
  logic [VEC_W-1:0]   cvtVec;
  logic               unusedInstr;

  assign unusedInstr = ^instrWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecS1   <= '0;
      scaleS1 <= '0;
    end else if (strobe.loadS1) begin
      vecS1   <= inVec;
      scaleS1 <= instrWord[SCALE_LSB +: SCALE_W];
    end
  end

  // lane k sits at the top end: lane 0 = most significant word
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int HI = VEC_W - 1 - k * WORD_W;

    vuf_lane_cvt #(.SCALE_W(SCALE_W)) cvt_i (
      .fixIn (vecS1[HI -: WORD_W]),
      .scale (scaleS1),
      .fltOut(cvtVec[HI -: WORD_W])
    );

    AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !outVec[HI]); // R5
    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.loadS2 && vecS1[HI -: WORD_W] == '0) |=> (outVec[HI -: WORD_W] == '0)); // R4
    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.loadS2 && vecS1[HI -: WORD_W] != '0) |=>
        (outVec[HI-1 -: EXP_W] >= 8'd96 && outVec[HI-1 -: EXP_W] <= 8'd159)); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outVec <= '0;
    else if (strobe.loadS2) outVec <= cvtVec;
  end
endmodule

// File: rtl/ufix_vec_to_float.sv
module ufix_vec_to_float
  import vuf_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SCALE_W   = 5,
  parameter int SCALE_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [NUM_LANES*WORD_W-1:0] inVec,
  input  logic [WORD_W-1:0]           instrWord,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [NUM_LANES*WORD_W-1:0] outVec
);
  ctrlStrobe_t strobe;

  vuf_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  vuf_datapath #(
    .NUM_LANES(NUM_LANES),
    .SCALE_W  (SCALE_W),
    .SCALE_LSB(SCALE_LSB)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inVec    (inVec),
    .instrWord(instrWord),
    .outVec   (outVec)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> $stable(outVec)); // R7
endmodule

// File: tb/ufix_vec_to_float_tb_top.sv
module ufix_vec_to_float_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         outReady = 1'b0;
  logic [127:0] inVec = '0;
  logic [31:0]  instrWord = '0;
  logic         inReady, outValid;
  logic [127:0] outVec;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ufix_vec_to_float dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inVec(inVec), .instrWord(instrWord), .outValid(outValid),
    .outReady(outReady), .outVec(outVec)
  );

  localparam int NV = 5;
  localparam logic [127:0] VEC_T [NV] = '{
    {32'h00000001, 32'hFFFFFFFF, 32'h01000001, 32'h01000003},
    {32'h01000002, 32'h02000003, 32'h80000000, 32'h00FFFFFF},
    {32'h000000FF, 32'h00000000, 32'h00000100, 32'h00000001},
    {32'h00000001, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
    {32'h00000003, 32'h00000002, 32'h00000007, 32'h40000000}
  };
  localparam logic [31:0] INS_T [NV] = '{
    32'h00000000, 32'hFFE0FFFF, 32'h00080000, 32'h001F0000, 32'h00010000
  };
  localparam logic [127:0] EXP_T [NV] = '{
    {32'h3F800000, 32'h4F800000, 32'h4B800000, 32'h4B800002},
    {32'h4B800001, 32'h4C000001, 32'h4F000000, 32'h4B7FFFFF},
    {32'h3F7F0000, 32'h00000000, 32'h3F800000, 32'h3B800000},
    {32'h30000000, 32'h40000000, 32'h00000000, 32'h3F800000},
    {32'h3FC00000, 32'h3F800000, 32'h40600000, 32'h4E000000}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runVec(input int idx);
    @(negedge clk);
    inVec = VEC_T[idx]; instrWord = INS_T[idx]; inValid = 1'b1; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R6 gap cycle", 128'(outValid), 128'd0);
    @(negedge clk);
    chk("R6 valid after two edges", 128'(outValid), 128'd1);
    chk("R1 R2 R3 lane values", outVec, EXP_T[idx]);
    for (int l = 0; l < 4; l++) begin
      chk("R5 sign clear", 128'(outVec[127 - 32*l]), 128'd0);
      if (outVec[127-32*l -: 32] != 0)
        chk("R10 exponent range",
            128'((outVec[126-32*l -: 8] >= 8'd96) && (outVec[126-32*l -: 8] <= 8'd159)), 128'd1);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 outValid in reset", 128'(outValid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 outValid after reset", 128'(outValid), 128'd0);
    chk("R9 inReady after reset", 128'(inReady), 128'd1);

    for (int i = 0; i < NV; i++) runVec(i);

    // R4: zero lanes across scales
    for (int s = 0; s < 32; s += 7) begin
      @(negedge clk);
      inVec = {32'h0, 32'h5, 32'h0, 32'h0}; instrWord = 32'(s) << 16; inValid = 1'b1; outReady = 1'b1;
      @(posedge clk); @(negedge clk); inValid = 1'b0;
      @(negedge clk);
      chk("R4 zero lane 0", 128'(outVec[127:96]), 128'd0);
      chk("R4 zero lanes 2 and 3", 128'(outVec[63:0]), 128'd0);
    end

    // R7 and R8: stall with two operands in flight
    @(negedge clk);
    outReady = 1'b0; inVec = VEC_T[0]; instrWord = INS_T[0]; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inVec = VEC_T[2]; instrWord = INS_T[2];
    @(posedge clk); @(negedge clk);
    inVec = VEC_T[4]; instrWord = INS_T[4];
    for (int c = 0; c < 3; c++) begin
      chk("R7 outValid held", 128'(outValid), 128'd1);
      chk("R7 outVec held", outVec, EXP_T[0]);
      chk("R8 inReady low while stalled", 128'(inReady), 128'd0);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    chk("R8 second result in order", outVec, EXP_T[2]);
    @(negedge clk);
    chk("R8 third result in order", outVec, EXP_T[4]);
    chk("R8 third result valid", 128'(outValid), 128'd1);
    @(negedge clk);
    chk("R8 no duplicate result", 128'(outValid), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule